// File: doc/BRIEF.md
# Frequency-Shift Identity Beacon

The block is a fully synchronous stand-in for a two-tone identity emitter. A fast clock drives a square-wave tone whose half-period is set by the data bit being sent. A 0 bit uses a short half-period, which gives the higher tone. A 1 bit uses a longer half-period, which gives the lower tone. The bits come from a 16-bit identity word held inside the block. The word is sent most significant bit first and repeats for as long as the block is enabled.

A single enable input controls all activity. While enable is low, the tone stays at 0, no bit boundaries are marked and the bit output reads 0. This is also the only time the identity word can be replaced. When enable rises, the stream starts again from the top bit of the word. A one-cycle pulse marks the first cycle of every bit.

The tone and the bit outputs are continuous signals and have no transfer handshake. None of the pins is a stream interface, so no valid/ready pair and no back-pressure rules apply.

Top module: `fsk_id_beacon`

## Requirements
- R1: Under reset all outputs are 0, and the identity word takes the value of parameter ID_INIT (default 1011110111011100 binary).
- R2: A half-period of the tone that starts while the bit is 0 lasts exactly N_UNITS+1 clock cycles.
- R3: A half-period of the tone that starts while the bit is 1 lasts exactly N_UNITS+K_UNITS+1 clock cycles, so the tone for a 1 is always the lower one.
- R4: One cycle after enable is sampled low, the tone, the bit output and the bit pulse are all 0, and they stay 0 while enable stays low.
- R5: Bits are sent from bit 15 down to bit 0. Each bit is held for BIT_DIV cycles, and bit 0 is followed by bit 15 again.
- R6: The bit pulse is high for exactly one cycle, in the first cycle of each bit. This includes the first bit, which starts one cycle after enable is sampled high.
- R7: The tone can change length only at a tone edge. Each half-period keeps the length chosen by the bit that was present when it began, even if it runs across a bit boundary.
- R8: When enable rises again after a pause in the middle of the stream, sending restarts from bit 15.
- R9: A load pulse while enable is low replaces the identity word. A load pulse while enable is high is ignored and leaves the stream unchanged.
- R10: N_UNITS is between 0 and 4 and K_UNITS is between 1 and 5. BIT_DIV is at least 4(N+1)(N+K+1)/K, rounded up, so the bit rate is no more than half the gap between the two tone frequencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each delay unit is one cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the tone and the identity stream while high |
| load_en | input | 1 | Loads load_id into the identity word when enable is low |
| load_id | input | ID_W | New identity word |
| tone | output | 1 | Square-wave tone |
| bit_out | output | 1 | Bit currently being sent (0 while idle) |
| bit_strobe | output | 1 | One-cycle pulse in the first cycle of each bit |

## Verification
Enable is registered once. The first bit pulse and the top bit therefore appear one cycle after enable is sampled high, and the first tone edge comes one cycle after that. Silence is due one cycle after enable is sampled low. The bench drives and samples on the falling edge and expects each result in exactly those cycles. It measures bit periods from pulse to pulse and half-periods from tone edge to tone edge. Each measured half-period is compared with the length chosen by the bit that was sampled in the cycle before that half-period began. The checks stop when enable falls, so a half-period cut short by disabling is never judged.

// File: rtl/fsk_beacon_pkg.sv
package fsk_beacon_pkg;

  // Smallest bit period (in fast cycles) that keeps the bit rate at or
  // below half the spacing of the two tone frequencies.
  function automatic int unsigned min_bit_div(input int unsigned n, input int unsigned k);
    return (4 * (n + 1) * (n + k + 1) + k - 1) / k;
  endfunction

  function automatic int unsigned cnt_w(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer
  import fsk_beacon_pkg::*;
#(
  parameter int unsigned BIT_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic run_o,
  output logic first_o,
  output logic adv_o
);
  localparam int unsigned CW = cnt_w(BIT_DIV);
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!enable) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign first_o = run_q && (cnt_q == '0);
  assign adv_o   = run_q && (cnt_q == LAST);
endmodule

// File: rtl/fsk_id_store.sv
module fsk_id_store
  import fsk_beacon_pkg::*;
#(
  parameter int unsigned     ID_W    = 16,
  parameter logic [ID_W-1:0] ID_INIT = 16'hBDDC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            load_en,
  input  logic [ID_W-1:0] load_id,
  input  logic            adv,
  output logic            bit_o
);
  localparam int unsigned IW = cnt_w(ID_W);
  localparam logic [IW-1:0] TOP = IW'(ID_W - 1);

  logic [ID_W-1:0] word_q;
  logic [IW-1:0]   idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  word_q <= ID_INIT;
    else if (load_en && !enable) word_q <= load_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= TOP;
    else if (!enable) idx_q <= TOP;
    else if (adv)     idx_q <= (idx_q == '0) ? TOP : idx_q - 1'b1;
  end

  assign bit_o = word_q[idx_q];
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_beacon_pkg::*;
#(
  parameter int unsigned N_UNITS = 1,
  parameter int unsigned K_UNITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bit_i,
  output logic tone_o
);
  localparam int unsigned HW = cnt_w(N_UNITS + K_UNITS + 2);
  localparam logic [HW-1:0] LIM_FAST = HW'(N_UNITS);
  localparam logic [HW-1:0] LIM_SLOW = HW'(N_UNITS + K_UNITS);

  logic [HW-1:0] hcnt_q;
  logic          tone_q;

  // The next half-period length is taken only when the tone toggles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0;
      hcnt_q <= '0;
    end else if (!go) begin
      tone_q <= 1'b0;
      hcnt_q <= '0;
    end else if (hcnt_q == '0) begin
      tone_q <= ~tone_q;
      hcnt_q <= bit_i ? LIM_SLOW : LIM_FAST;
    end else begin
      hcnt_q <= hcnt_q - 1'b1;
    end
  end

  assign tone_o = tone_q;
endmodule

// File: rtl/fsk_id_beacon.sv
module fsk_id_beacon
  import fsk_beacon_pkg::*;
#(
  parameter int unsigned     ID_W    = 16,
  parameter logic [ID_W-1:0] ID_INIT = 16'hBDDC,
  parameter int unsigned     N_UNITS = 1,
  parameter int unsigned     K_UNITS = 2,
  parameter int unsigned     BIT_DIV = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            load_en,
  input  logic [ID_W-1:0] load_id,
  output logic            tone,
  output logic            bit_out,
  output logic            bit_strobe
);
  logic run, first, adv, raw_bit;

  fsk_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .run_o(run), .first_o(first), .adv_o(adv)
  );

  fsk_id_store #(.ID_W(ID_W), .ID_INIT(ID_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .load_en(load_en), .load_id(load_id), .adv(adv), .bit_o(raw_bit)
  );

  fsk_tone_gen #(.N_UNITS(N_UNITS), .K_UNITS(K_UNITS)) u_tone (
    .clk(clk), .rst_n(rst_n), .go(enable && run),
    .bit_i(raw_bit), .tone_o(tone)
  );

  assign bit_out    = run && raw_bit;
  assign bit_strobe = first;
endmodule

// File: rtl/fsk_id_beacon_chk.sv
module fsk_id_beacon_chk
  import fsk_beacon_pkg::*;
#(
  parameter int unsigned N_UNITS = 1,
  parameter int unsigned K_UNITS = 2,
  parameter int unsigned BIT_DIV = 32
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tone,
  input logic bit_out,
  input logic bit_strobe
);
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (!tone)  hi_len <= '0;
    else if (hi_len != 8'hFF) hi_len <= hi_len + 1'b1;
  end

  initial begin
    a_param_range_r10: assert (N_UNITS <= 4 && K_UNITS >= 1 && K_UNITS <= 5
                               && BIT_DIV >= min_bit_div(N_UNITS, K_UNITS))
      else $error("parameter set out of range");
  end

  p_quiet_tone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tone);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  p_pulse_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(enable));

  p_bit_moves_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_out != $past(bit_out)) |-> (bit_strobe || !$past(enable)));

  p_half_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $fell(tone)) |-> (hi_len >= 8'(N_UNITS + 1)));
endmodule

bind fsk_id_beacon fsk_id_beacon_chk #(
  .N_UNITS(N_UNITS), .K_UNITS(K_UNITS), .BIT_DIV(BIT_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tone(tone),
  .bit_out(bit_out), .bit_strobe(bit_strobe)
);

// File: tb/test_fsk_id_beacon.sv
module test_fsk_id_beacon;
  localparam int NU = 1;
  localparam int KU = 2;
  localparam int BD = 32;
  localparam logic [15:0] INIT = 16'hBDDC;
  localparam int LEN0 = NU + 1;
  localparam int LEN1 = NU + KU + 1;
  localparam int MINBD = (4 * (NU + 1) * (NU + KU + 1) + KU - 1) / KU;

  // {identity word, number of bits to watch}
  localparam logic [23:0] VEC [5] = '{
    {16'hBDDC, 8'd20}, {16'h0000, 8'd18}, {16'hFFFF, 8'd18},
    {16'h8001, 8'd34}, {16'h5A5A, 8'd24}
  };

  logic clk = 0, rst_n = 0, enable = 0, load_en = 0;
  logic [15:0] load_id = '0;
  logic tone, bit_out, bit_strobe;

  fsk_id_beacon #(.ID_W(16), .ID_INIT(INIT), .N_UNITS(NU), .K_UNITS(KU), .BIT_DIV(BD))
    i_fsk_id_beacon (.clk(clk), .rst_n(rst_n), .enable(enable), .load_en(load_en),
                     .load_id(load_id), .tone(tone), .bit_out(bit_out), .bit_strobe(bit_strobe));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  bit mon_on = 0, seen_first = 0, half_valid = 0;
  logic [15:0] exp_id;
  int exp_idx, gap, run_len, since_en, nstrobe;
  logic prev_tone, prev_bit, half_bit;

  task automatic mon_reset(input logic [15:0] id);
    exp_id = id; seen_first = 0; half_valid = 0; prev_tone = 0; prev_bit = 0;
    gap = 0; run_len = 0; since_en = 0; nstrobe = 0;
  endtask

  task automatic step();
    @(negedge clk);
    if (mon_on) begin
      since_en++;
      if (bit_strobe) begin
        nstrobe++;
        if (!seen_first) begin
          check(since_en == 1, "R6 first pulse one cycle after enable", since_en, 1);
          check(bit_out == exp_id[15], "R8 stream starts at bit 15", bit_out, exp_id[15]);
          exp_idx = 15; seen_first = 1;
        end else begin
          check(gap == BD, "R5 bit period", gap, BD);
          check(gap >= MINBD, "R10 bit period above bound", gap, MINBD);
          exp_idx = (exp_idx == 0) ? 15 : exp_idx - 1;
          check(bit_out == exp_id[exp_idx], "R5 bit order", bit_out, exp_id[exp_idx]);
        end
        gap = 1;
      end else begin
        gap++;
      end
      if (tone != prev_tone) begin
        if (half_valid) begin
          if (half_bit) check(run_len == LEN1, "R3 half-period for 1 (R7)", run_len, LEN1);
          else          check(run_len == LEN0, "R2 half-period for 0 (R7)", run_len, LEN0);
        end
        half_bit = prev_bit; half_valid = 1; run_len = 1;
      end else begin
        run_len++;
      end
      prev_tone = tone; prev_bit = bit_out;
    end
  endtask

  task automatic session(input logic [15:0] id, input int nbits);
    mon_reset(id);
    enable = 1; mon_on = 1;
    while (nstrobe < nbits) step();
    mon_on = 0; enable = 0;
    step();
  endtask

  task automatic load_word(input logic [15:0] id);
    load_id = id; load_en = 1;
    step();
    load_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit quiet;
    // R1 reset state
    repeat (3) step();
    check(tone == 0 && bit_out == 0 && bit_strobe == 0, "R1 outputs in reset",
          {tone, bit_out, bit_strobe}, 0);
    rst_n = 1;
    step();
    // R1 default identity streams without any load
    session(INIT, 17);

    // vector table: load while idle (R9), then stream
    for (int v = 0; v < 5; v++) begin
      load_word(VEC[v][23:8]);
      step();
      session(VEC[v][23:8], int'(VEC[v][7:0]));
    end

    // R4 silence after enable drops, held over a window
    load_word(16'h0F0F);
    enable = 1;
    repeat (40) step();
    enable = 0;
    step();
    check(tone == 0 && bit_out == 0 && bit_strobe == 0, "R4 silent one cycle after disable",
          {tone, bit_out, bit_strobe}, 0);
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      step();
      if (tone || bit_out || bit_strobe) quiet = 0;
    end
    check(quiet, "R4 stays silent while disabled", quiet, 1);

    // R8 restart mid-stream from bit 15
    mon_reset(16'h0F0F); enable = 1; mon_on = 1;
    while (nstrobe < 5) step();
    mon_on = 0; enable = 0;
    repeat (3) step();
    session(16'h0F0F, 3);

    // R9 load while enabled is ignored
    mon_reset(16'h0F0F); enable = 1; mon_on = 1;
    while (nstrobe < 3) step();
    load_id = 16'hF0F0; load_en = 1;
    step();
    load_en = 0;
    while (nstrobe < 20) step();
    mon_on = 0; enable = 0;
    step();
    session(16'h0F0F, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule